// File: doc/BRIEF.md
# Short-Frame-Sync PCM Serial Port

This block is the digital serial port of a single-channel voice codec. It moves one 8-bit sample per frame in each direction over a bit-serial PCM link. One bit clock and two independent frame syncs drive the link. The design's clock input is the bit clock itself. The serial data rate therefore equals the clock frequency, and any standard rate from 64 kHz to 2048 kHz is covered without change.

The receive side samples the serial input on the falling clock edge. A sync pulse that goes high marks the slot carrying the most significant bit. After the eighth bit, the assembled byte is handed out with a one-cycle strobe. The transmit side also starts a frame on a rising sync. On the rising clock edge that sees the sync go high, it captures the parallel byte and drives it MSB first for exactly eight slots. Outside those slots the output enable is low.

The logic has no notion of nominal frame length. Only sync edges and the 8-slot counters determine framing, so any sync rate in the 6 to 9 kHz band is accepted.

Top module: `pcm_sfs_port`

## Requirements
- R1: While rst_ni is low, pcm_oe_o, pcm_o, tx_load_o and rx_valid_o are 0 and rx_data_o is 0.
- R2: A receive frame starts at the falling clock edge where rsync_i is sampled 1 after being sampled 0 at the previous falling edge. pcm_i sampled at that edge is bit 7 (MSB). The next seven falling edges supply bits 6 down to 0.
- R3: At the falling edge that samples bit 0, rx_data_o takes the assembled byte and rx_valid_o goes high for exactly one clock period. At all other times rx_data_o holds its value.
- R4: Serial input after the eighth bit of a frame is ignored: rx_data_o and rx_valid_o do not change until a new rsync_i rising edge begins a frame.
- R5: If a new rsync_i rising edge arrives before eight bits are taken, the partial byte is dropped without a strobe and the count restarts at bit 7.
- R6: At the rising clock edge where xsync_i is sampled 1 after being 0, tx_data_i is captured. tx_load_o is high for that one clock period, pcm_oe_o goes high and pcm_o carries tx_data_i bit 7.
- R7: The following seven rising edges put captured bits 6 down to 0 on pcm_o. At the next rising edge, pcm_oe_o falls unless a new frame starts. pcm_o is 0 whenever pcm_oe_o is 0.
- R8: Changes to tx_data_i between frame starts do not affect the bits being shifted out.
- R9: An xsync_i rising edge during a transmit frame restarts the frame with the new byte. A rising edge in the slot right after the eighth keeps pcm_oe_o high without a gap.
- R10: A sync held high for several clock periods counts as one frame start only.
- R11: Transmit and receive framing are independent of each other and of the interval between syncs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock; data rate equals its frequency |
| rst_ni | input | 1 | Asynchronous active-low reset |
| xsync_i | input | 1 | Transmit frame sync, phase-aligned to clk_i |
| rsync_i | input | 1 | Receive frame sync, phase-aligned to clk_i |
| pcm_i | input | 1 | Serial receive data |
| tx_data_i | input | 8 | Parallel byte to transmit |
| pcm_o | output | 1 | Serial transmit data |
| pcm_oe_o | output | 1 | Drive enable for pcm_o (low means tri-state) |
| tx_load_o | output | 1 | One-cycle strobe: tx_data_i captured |
| rx_data_o | output | 8 | Last complete receive byte |
| rx_valid_o | output | 1 | One-cycle strobe: new receive byte |

## Verification
Two events can land on the same transmit edge: the retirement of the eighth slot and the capture of the next frame's byte. The bench provokes this by spacing xsync_i pulses exactly eight clocks apart. The reference model then expects pcm_oe_o to stay high and the new MSB to replace the old LSB with no idle slot. On the receive side, a byte strobe is immediately followed by a new frame start, and short sync periods force an abort before the strobe can occur. In both cases the queue-based model predicts whether a strobe appears, and every clock is compared against it.

// File: rtl/pcm_sfs_pkg.sv
package pcm_sfs_pkg;
  localparam int unsigned PCM_BYTE_W = 8;

  function automatic int unsigned slot_cnt_w(input int unsigned n_slots);
    return $clog2(n_slots + 1);
  endfunction
endpackage

// File: rtl/pcm_sync_edge.sv
module pcm_sync_edge #(
  parameter bit NEG_EDGE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic rise_o
);
  logic sync_q;

  generate
    if (NEG_EDGE) begin : g_neg
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= 1'b0;
        else         sync_q <= sync_i;
      end
    end else begin : g_pos
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= 1'b0;
        else         sync_q <= sync_i;
      end
    end
  endgenerate

  assign rise_o = sync_i & ~sync_q;
endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser #(
  parameter int unsigned DATA_W = pcm_sfs_pkg::PCM_BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  localparam int unsigned CNT_W = pcm_sfs_pkg::slot_cnt_w(DATA_W);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  // Receive side runs on the falling bit-clock edge.
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else if (start_i) begin
      sh_q    <= {{(DATA_W-1){1'b0}}, bit_i};
      cnt_q   <= CNT_W'(1);
      valid_o <= 1'b0;
    end else if (cnt_q == LAST_CNT) begin
      data_o  <= {sh_q[DATA_W-2:0], bit_i};
      cnt_q   <= '0;
      valid_o <= 1'b1;
    end else if (cnt_q != '0) begin
      sh_q    <= {sh_q[DATA_W-2:0], bit_i};
      cnt_q   <= cnt_q + CNT_W'(1);
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
    end
  end

  a_r3_valid_single: assert property (@(negedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  a_r3_data_hold: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));
  a_r5_abort_no_strobe: assert property (@(negedge clk_i) disable iff (!rst_ni)
    start_i |=> !valid_o);
endmodule

// File: rtl/pcm_tx_ser.sv
module pcm_tx_ser #(
  parameter int unsigned DATA_W = pcm_sfs_pkg::PCM_BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              bit_o,
  output logic              oe_o,
  output logic              load_o
);
  localparam int unsigned CNT_W = pcm_sfs_pkg::slot_cnt_w(DATA_W);
  localparam logic [CNT_W-1:0] END_CNT = CNT_W'(DATA_W);

  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      bit_o  <= 1'b0;
      oe_o   <= 1'b0;
      load_o <= 1'b0;
    end else if (start_i) begin
      sh_q   <= {data_i[DATA_W-2:0], 1'b0};
      bit_o  <= data_i[DATA_W-1];
      oe_o   <= 1'b1;
      cnt_q  <= CNT_W'(1);
      load_o <= 1'b1;
    end else begin
      load_o <= 1'b0;
      if (cnt_q == END_CNT) begin
        cnt_q <= '0;
        oe_o  <= 1'b0;
        bit_o <= 1'b0;
      end else if (cnt_q != '0) begin
        bit_o <= sh_q[DATA_W-1];
        sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // Checker-only run length of the enable since the last load.
  logic [CNT_W:0] chk_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             chk_run_q <= '0;
    else if (load_o || !oe_o) chk_run_q <= '0;
    else                     chk_run_q <= chk_run_q + 1'b1;
  end

  a_r6_oe_rise_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> load_o);
  a_r6_msb_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> (bit_o == $past(data_i[DATA_W-1])));
  a_r7_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> !bit_o);
  a_r7_slot_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> (chk_run_q < (CNT_W+1)'(DATA_W)));
endmodule

// File: rtl/pcm_sfs_port.sv
module pcm_sfs_port #(
  parameter int unsigned DATA_W = pcm_sfs_pkg::PCM_BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xsync_i,
  input  logic              rsync_i,
  input  logic              pcm_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              pcm_o,
  output logic              pcm_oe_o,
  output logic              tx_load_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o
);
  logic rx_start, tx_start;

  pcm_sync_edge #(.NEG_EDGE(1'b1)) u_rx_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(rsync_i), .rise_o(rx_start)
  );

  pcm_sync_edge #(.NEG_EDGE(1'b0)) u_tx_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(xsync_i), .rise_o(tx_start)
  );

  pcm_rx_deser #(.DATA_W(DATA_W)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(rx_start), .bit_i(pcm_i),
    .data_o(rx_data_o), .valid_o(rx_valid_o)
  );

  pcm_tx_ser #(.DATA_W(DATA_W)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(tx_start), .data_i(tx_data_i),
    .bit_o(pcm_o), .oe_o(pcm_oe_o), .load_o(tx_load_o)
  );

  a_r10_load_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_o |-> ($past(xsync_i) && !$past(xsync_i, 2)));
endmodule

// File: tb/pcm_sfs_port_bench.sv
module pcm_sfs_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       xsync = 1'b0, rsync = 1'b0, pcm_in = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       pcm_out, pcm_oe, tx_load, rx_valid;
  logic [7:0] rx_data;

  int n_vec = 0, n_bad = 0;

  always #5 clk = ~clk;

  pcm_sfs_port u_pcm_sfs_port (
    .clk_i(clk), .rst_ni(rst_n), .xsync_i(xsync), .rsync_i(rsync),
    .pcm_i(pcm_in), .tx_data_i(tx_data), .pcm_o(pcm_out), .pcm_oe_o(pcm_oe),
    .tx_load_o(tx_load), .rx_data_o(rx_data), .rx_valid_o(rx_valid)
  );

  // Behavioural reference: receive bits gathered in a queue.
  bit   rs_prev = 0, rx_act = 0, exp_valid = 0;
  bit   rx_q[$];
  logic [7:0] exp_rx = 8'h00;
  always @(negedge clk) begin
    if (!rst_n) begin
      rs_prev = 0; rx_act = 0; exp_valid = 0; exp_rx = 8'h00; rx_q.delete();
    end else begin
      exp_valid = 0;
      if (rsync && !rs_prev) begin
        rx_q.delete(); rx_q.push_back(pcm_in); rx_act = 1;
      end else if (rx_act) begin
        rx_q.push_back(pcm_in);
      end
      if (rx_q.size() == 8) begin
        for (int i = 0; i < 8; i++) exp_rx[7-i] = rx_q[i];
        exp_valid = 1; rx_act = 0; rx_q.delete();
      end
      rs_prev = rsync;
    end
  end

  // Behavioural reference: transmit slot index, -1 when idle.
  bit   xs_prev = 0, exp_load = 0;
  int   tx_slot = -1;
  logic [7:0] tx_cap = 8'h00;
  always @(posedge clk) begin
    if (!rst_n) begin
      xs_prev = 0; exp_load = 0; tx_slot = -1; tx_cap = 8'h00;
    end else begin
      exp_load = 0;
      if (xsync && !xs_prev) begin
        tx_cap = tx_data; tx_slot = 0; exp_load = 1;
      end else if (tx_slot >= 0) begin
        tx_slot++;
        if (tx_slot == 8) tx_slot = -1;
      end
      xs_prev = xsync;
    end
  end

  task automatic report(string tag, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    bit e_oe;
    bit e_bit;
    e_oe  = (tx_slot >= 0);
    e_bit = e_oe ? tx_cap[7 - tx_slot] : 1'b0;
    report({tag, "/R6"}, "tx_load", int'(tx_load), int'(exp_load));
    report({tag, "/R7"}, "pcm_oe", int'(pcm_oe), int'(e_oe));
    report({tag, "/R7"}, "pcm_o", int'(pcm_out), int'(e_bit));
    report({tag, "/R3"}, "rx_valid", int'(rx_valid), int'(exp_valid));
    report({tag, "/R2"}, "rx_data", int'(rx_data), int'(exp_rx));
  endtask

  task automatic run_phase(string tag, int xp, int xw, int xo,
                           int rp, int rw, int ro, int n);
    for (int c = 0; c < n; c++) begin
      @(posedge clk); #2;
      xsync   = ((c + xo) % xp) < xw;
      rsync   = ((c + ro) % rp) < rw;
      pcm_in  = 1'($urandom);
      tx_data = 8'($urandom);
      #6;
      compare(tag);
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    xsync = 1'b1; rsync = 1'b1; pcm_in = 1'b1; tx_data = 8'hFF;
    repeat (3) @(posedge clk);
    #8;
    report("R1", "pcm_oe", int'(pcm_oe), 0);
    report("R1", "pcm_o", int'(pcm_out), 0);
    report("R1", "tx_load", int'(tx_load), 0);
    report("R1", "rx_valid", int'(rx_valid), 0);
    report("R1", "rx_data", int'(rx_data), 0);
    @(posedge clk); #2;
    xsync = 1'b0; rsync = 1'b0; rst_n = 1'b1;
    #6; compare("R1");
    run_phase("R2", 8, 1, 0, 8, 1, 3, 200);   // back-to-back frames both ways
    run_phase("R9", 8, 1, 5, 9, 1, 0, 120);   // tx retire and reload share an edge
    run_phase("R4", 13, 1, 0, 16, 1, 7, 250); // trailing rx bits ignored
    run_phase("R5", 6, 1, 2, 5, 1, 0, 200);   // rx abort, tx restart
    run_phase("R8", 11, 1, 4, 10, 1, 2, 200); // tx_data churns every clock
    run_phase("R10", 14, 3, 0, 15, 4, 6, 250);// held syncs
    run_phase("R11", 40, 1, 0, 27, 1, 9, 400);// unrelated long periods
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule